// File: doc/BRIEF.md
# TDM Audio Serial Frame Receiver

This block takes a time-division-multiplexed audio stream arriving on a single serial data line and turns it into parallel samples. The bit clock of the stream is the block's clock. A word-clock (frame-sync) input marks the start of each frame. The block divides each frame into equal channel slots, shifts in one sample per slot with the most significant bit first, and presents every finished sample as a parallel word. Each word carries a channel index and a one-cycle valid strobe.

Three configuration inputs select the stream layout. One selects 2, 4 or 8 channels per line, one selects a frame of 256 or 128 bit clocks, and one selects whether the frame sync is a single-clock pulse or stays high for one slot. The frame start is always taken from the rising edge of the sync. The data for the first slot begins on the bit clock after that edge.

The block also checks where each sync edge falls. A rising edge at the wrong bit position, or a falling edge that does not match the chosen pulse style, sets a sticky framing-error flag. A rising edge at the wrong position also realigns the receiver to that edge. Configuration is sampled only at frame boundaries, so it can be changed at any time without corrupting a frame in progress.

Top module: `tdm_frame_rx`

## Requirements
- R1: After reset `sampleValid` and `framingErr` are 0. No sample is produced, and no error is flagged, until the first rising edge of `frameSync` is seen.
- R2: `frameSync` and `serData` are sampled on the rising clock edge. A rising sync edge is detected when the sync is 1 now and was 0 at the previous edge. The first bit of slot 0 is sampled at the edge after the rising edge. Each sample is 24 bits, MSB first. `sampleValid` is high for exactly one cycle, in the cycle after the edge that sampled the last captured bit of the slot.
- R3: `cfgChanSel` selects the channel count: 0 gives 2, 1 gives 4, 2 or 3 gives 8. The slot length is the frame length divided by the channel count. `sampleChan` is the slot number, starting at 0 for the first slot after the sync edge.
- R4: `cfgHalfFrame` selects the frame length: 0 gives 256 bit clocks, 1 gives 128 bit clocks. The next rising sync edge is expected at the edge that samples the last bit of the frame.
- R5: Slot bits after the 24th have no effect on the output word. When a slot is shorter than 24 bits (16 bits, with 8 channels in a 128-clock frame), all slot bits are captured. The word then holds the upper 16 bits of the sample, right-aligned, and valid follows the last slot bit.
- R6: With `cfgSlotSync`=0 (pulse style), the sync must be low at the edge after its rising edge. A sync still high at that edge sets `framingErr`.
- R7: With `cfgSlotSync`=1 (slot style), the sync must be seen high for exactly one slot length of edges, starting at the rising edge. A falling edge at any other count sets `framingErr`.
- R8: A rising sync edge at any other bit position sets `framingErr`. It also restarts the frame, so the next edge samples bit 0 of slot 0. The slot that was cut short produces no output.
- R9: `framingErr` stays at 1 until reset, while reception of later frames goes on normally.
- R10: A change on any configuration input takes effect only from the next frame start. The frame in progress completes with the configuration it began with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all sampling on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| frameSync | input | 1 | Word clock / frame sync; frame starts at its rising edge |
| serData | input | 1 | Serial audio data, MSB first per slot |
| cfgChanSel | input | 2 | Channels per line: 0=2, 1=4, 2 or 3=8 |
| cfgHalfFrame | input | 1 | Frame length: 0=256, 1=128 bit clocks |
| cfgSlotSync | input | 1 | Sync style: 0=single-clock pulse, 1=slot-wide pulse |
| sampleData | output | 24 | Received sample word |
| sampleChan | output | 3 | Channel index of the sample word |
| sampleValid | output | 1 | One-cycle strobe marking a new sample |
| framingErr | output | 1 | Sticky framing-error flag |

## Verification
The stream is tried in every channel count with both frame lengths and both sync styles. Junk is driven into the unused slot bits, so a receiver that shifts too far or emits too late is told apart from a correct one. The 16-bit slots show whether capture length follows the slot. A configuration flip in the middle of a frame separates frame-boundary loading from immediate loading.

Deliberate sync faults are also applied: a pulse held one clock too long, a slot-wide pulse that falls early, and a rise in the middle of a slot. These show that each fault sets the flag, that the flag persists while later frames still decode on the new alignment, and that clean streams of every kind leave it clear.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;

  // Width of the channel index carried with every sample (up to 8 slots).
  parameter int CHAN_IDX_W = 3;

  // Strobes from the slot control into the sample datapath.
  typedef struct packed {
    logic                  shiftEn;   // capture serData this edge
    logic                  firstBit;  // captured bit is the first of its slot
    logic                  emit;      // captured bit completes the sample
    logic [CHAN_IDX_W-1:0] chanIdx;   // slot being captured
  } rxStrobes_t;

endpackage

// File: rtl/tdm_rx_ctrl.sv
module tdm_rx_ctrl
  import tdm_rx_pkg::*;
#(
  parameter int MAX_FRAME = 256,
  parameter int SAMPLE_W  = 24
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameSync,
  input  logic [1:0] cfgChanSel,
  input  logic       cfgHalfFrame,
  input  logic       cfgSlotSync,
  output rxStrobes_t strobes,
  output logic       framingErr
);

  localparam int CNT_W = $clog2(MAX_FRAME);
  localparam int LOG_W = $clog2(CNT_W + 1);
  localparam logic [CNT_W-1:0] SAMP_LAST = CNT_W'(SAMPLE_W - 1);

  // Sync edge detection
  logic syncPrev;
  logic syncRise;
  logic syncFall;

  // Frame position and lock
  logic             locked;
  logic [CNT_W-1:0] cnt;

  // Configuration applied to the current frame
  logic [1:0] actChanSel;
  logic       actHalf;
  logic       actSlotSync;

  // Derived frame geometry
  logic [2:0]       chanLog;
  logic [LOG_W-1:0] slotLog;
  logic [CNT_W-1:0] lastCnt;
  logic [CNT_W-1:0] slotMask;
  logic [CNT_W-1:0] capLast;
  logic [CNT_W-1:0] fallCnt;
  logic [CNT_W-1:0] bitInSlot;

  // Frame events
  logic frameEnd;
  logic unexpRise;
  logic badFall;
  logic loadCfg;

  assign syncRise = frameSync & ~syncPrev;
  assign syncFall = ~frameSync & syncPrev;

  always_comb begin
    case (actChanSel)
      2'd0:    chanLog = 3'd1;
      2'd1:    chanLog = 3'd2;
      default: chanLog = 3'd3;
    endcase
  end

  assign lastCnt   = {CNT_W{1'b1}} >> actHalf;
  assign slotMask  = lastCnt >> chanLog;
  assign slotLog   = LOG_W'(CNT_W) - LOG_W'(actHalf) - LOG_W'(chanLog);
  assign capLast   = (slotMask < SAMP_LAST) ? slotMask : SAMP_LAST;
  assign fallCnt   = actSlotSync ? slotMask : '0;
  assign bitInSlot = cnt & slotMask;

  assign frameEnd  = locked && (cnt == lastCnt);
  assign unexpRise = locked && syncRise && !frameEnd;
  assign badFall   = locked && syncFall && (cnt != fallCnt);
  assign loadCfg   = syncRise || !locked || frameEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncPrev    <= 1'b0;
      locked      <= 1'b0;
      cnt         <= '0;
      actChanSel  <= 2'd0;
      actHalf     <= 1'b0;
      actSlotSync <= 1'b0;
    end else begin
      syncPrev <= frameSync;
      if (syncRise) begin
        locked <= 1'b1;
      end
      if (loadCfg) begin
        cnt         <= '0;
        actChanSel  <= cfgChanSel;
        actHalf     <= cfgHalfFrame;
        actSlotSync <= cfgSlotSync;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      framingErr <= 1'b0;
    end else if (unexpRise || badFall) begin
      framingErr <= 1'b1;
    end
  end

  always_comb begin
    strobes.shiftEn  = locked && !unexpRise && (bitInSlot <= capLast);
    strobes.firstBit = (bitInSlot == '0);
    strobes.emit     = strobes.shiftEn && (bitInSlot == capLast);
    strobes.chanIdx  = CHAN_IDX_W'(cnt >> slotLog);
  end

  // R8: a rising sync edge always puts the next edge in slot 0
  assert_rise_resync_R8: assert property (@(posedge clk) disable iff (!rstN)
    syncRise |=> (strobes.chanIdx == '0));

  // R9: the framing error never clears without reset
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    framingErr |=> framingErr);

  // R10: configuration only moves when a frame begins
  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (locked && cnt != '0) |-> ($stable(actChanSel) && $stable(actHalf) && $stable(actSlotSync)));

  // R4: the position never runs past the selected frame length
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> (cnt <= lastCnt));

endmodule

// File: rtl/tdm_rx_datapath.sv
module tdm_rx_datapath
  import tdm_rx_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  serData,
  input  rxStrobes_t            strobes,
  output logic [SAMPLE_W-1:0]   sampleData,
  output logic [CHAN_IDX_W-1:0] sampleChan,
  output logic                  sampleValid
);

  logic [SAMPLE_W-1:0] shReg;
  logic [SAMPLE_W-1:0] shNext;

  assign shNext = strobes.firstBit ? {{(SAMPLE_W-1){1'b0}}, serData}
                                   : {shReg[SAMPLE_W-2:0], serData};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
    end else if (strobes.shiftEn) begin
      shReg <= shNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleData  <= '0;
      sampleChan  <= '0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= strobes.emit;
      if (strobes.emit) begin
        sampleData <= shNext;
        sampleChan <= strobes.chanIdx;
      end
    end
  end

  // R2: the valid strobe lasts a single cycle
  assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);

  // R2: the word on the outputs holds between strobes
  assert_word_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.emit |=> ($stable(sampleData) && $stable(sampleChan)));

endmodule

// File: rtl/tdm_frame_rx.sv
module tdm_frame_rx
  import tdm_rx_pkg::*;
#(
  parameter int MAX_FRAME = 256,
  parameter int SAMPLE_W  = 24
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  frameSync,
  input  logic                  serData,
  input  logic [1:0]            cfgChanSel,
  input  logic                  cfgHalfFrame,
  input  logic                  cfgSlotSync,
  output logic [SAMPLE_W-1:0]   sampleData,
  output logic [CHAN_IDX_W-1:0] sampleChan,
  output logic                  sampleValid,
  output logic                  framingErr
);

  rxStrobes_t strobes;

  tdm_rx_ctrl #(
    .MAX_FRAME (MAX_FRAME),
    .SAMPLE_W  (SAMPLE_W)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .frameSync    (frameSync),
    .cfgChanSel   (cfgChanSel),
    .cfgHalfFrame (cfgHalfFrame),
    .cfgSlotSync  (cfgSlotSync),
    .strobes      (strobes),
    .framingErr   (framingErr)
  );

  tdm_rx_datapath #(
    .SAMPLE_W (SAMPLE_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .serData     (serData),
    .strobes     (strobes),
    .sampleData  (sampleData),
    .sampleChan  (sampleChan),
    .sampleValid (sampleValid)
  );

endmodule

// File: tb/tdm_frame_rx_tb.sv
module tdm_frame_rx_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        frameSync;
  logic        serData;
  logic [1:0]  cfgChanSel;
  logic        cfgHalfFrame;
  logic        cfgSlotSync;
  logic [23:0] sampleData;
  logic [2:0]  sampleChan;
  logic        sampleValid;
  logic        framingErr;

  always #4 clk = ~clk;

  tdm_frame_rx u_dut (
    .clk          (clk),
    .rstN         (rstN),
    .frameSync    (frameSync),
    .serData      (serData),
    .cfgChanSel   (cfgChanSel),
    .cfgHalfFrame (cfgHalfFrame),
    .cfgSlotSync  (cfgSlotSync),
    .sampleData   (sampleData),
    .sampleChan   (sampleChan),
    .sampleValid  (sampleValid),
    .framingErr   (framingErr)
  );

  typedef struct {
    int    chan;
    int    data;
    string tag;
  } item_t;

  item_t expQ[$];
  int    total   = 0;
  int    bad     = 0;
  int    frameNo = 0;
  bit    done    = 0;

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int smp(int f, int c);
    return (f * 32'h2F1B3 + c * 32'h51D7 + 32'h9A3C5 ^ (c << 17)) & 32'hFFFFFF;
  endfunction

  // Monitor: pop one expected word per valid strobe
  always @(negedge clk) begin
    item_t it;
    if (sampleValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2 unexpected valid", {5'd0, sampleChan, sampleData}, 0);
      end else begin
        it = expQ.pop_front();
        check(sampleChan == it.chan[2:0] && sampleData == it.data[23:0], it.tag,
              {5'd0, sampleChan, sampleData}, (it.chan << 24) | it.data);
      end
    end
  end

  task automatic setCfg(int cs, int hf, int ss);
    cfgChanSel   = cs[1:0];
    cfgHalfFrame = hf[0];
    cfgSlotSync  = ss[0];
  endtask

  task automatic doReset(string tag);
    @(negedge clk);
    #1;
    check(expQ.size() == 0, {tag, " missing samples"}, expQ.size(), 0);
    expQ.delete();
    @(negedge clk);
    rstN      = 1'b0;
    frameSync = 1'b0;
    serData   = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic startStream();
    @(negedge clk) frameSync = 1'b0;
    @(negedge clk) frameSync = 1'b1;
  endtask

  // Drive one frame; hold = extra edges the sync stays high at frame start
  task automatic playFrame(int cs, int hf, int hold, int ncs, int nhf, int nss,
                           bit raise, string tag);
    int    fLen = hf ? 128 : 256;
    int    nCh  = (cs == 0) ? 2 : (cs == 1) ? 4 : 8;
    int    sLen = fLen / nCh;
    int    cap  = (sLen < 24) ? sLen : 24;
    int    f    = frameNo++;
    item_t it;
    for (int c = 0; c < nCh; c++) begin
      it.chan = c;
      it.data = smp(f, c) >> (24 - cap);
      it.tag  = tag;
      expQ.push_back(it);
    end
    for (int k = 0; k < fLen; k++) begin
      int b = k % sLen;
      int v = smp(f, k / sLen);
      @(negedge clk);
      if (k == fLen / 2) setCfg(ncs, nhf, nss);
      serData   = (b < cap) ? v[23 - b] : ((k ^ (k >> 2)) & 1) != 0;
      frameSync = (raise && k == fLen - 1) || (k < hold);
    end
  endtask

  // Drive a frame cut short by a sync rise at position stopK (pulse style)
  task automatic partialFrame(int cs, int hf, int stopK, string tag);
    int    fLen = hf ? 128 : 256;
    int    nCh  = (cs == 0) ? 2 : (cs == 1) ? 4 : 8;
    int    sLen = fLen / nCh;
    int    cap  = (sLen < 24) ? sLen : 24;
    int    f    = frameNo++;
    item_t it;
    for (int c = 0; c < nCh; c++) begin
      if (c * sLen + cap - 1 < stopK) begin
        it.chan = c;
        it.data = smp(f, c) >> (24 - cap);
        it.tag  = tag;
        expQ.push_back(it);
      end
    end
    for (int k = 0; k <= stopK; k++) begin
      int b = k % sLen;
      int v = smp(f, k / sLen);
      @(negedge clk);
      serData   = (b < cap) ? v[23 - b] : 1'b1;
      frameSync = (k == stopK);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN      = 1'b0;
    frameSync = 1'b0;
    serData   = 1'b0;
    setCfg(2, 0, 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state and silence before the first sync
    check(sampleValid == 1'b0, "R1 valid after reset", sampleValid, 0);
    check(framingErr == 1'b0, "R1 error after reset", framingErr, 0);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk) serData = i[0] ^ i[2];
    end
    check(framingErr == 1'b0, "R1 error before sync", framingErr, 0);

    // R2 R3 R5: 8 channels, 256 frame, pulse sync, junk in spare bits
    setCfg(2, 0, 0);
    startStream();
    playFrame(2, 0, 0, 2, 0, 0, 1, "R2");
    playFrame(2, 0, 0, 2, 0, 0, 1, "R3");
    playFrame(2, 0, 0, 2, 0, 0, 1, "R5");
    check(framingErr == 1'b0, "R2 no error on clean stream", framingErr, 0);
    doReset("R2");

    // R7 R3: slot-wide sync, 4 then 2 channels
    setCfg(1, 0, 1);
    startStream();
    playFrame(1, 0, 63, 1, 0, 1, 1, "R7");
    playFrame(1, 0, 63, 0, 0, 1, 1, "R7");
    playFrame(0, 0, 127, 0, 0, 1, 1, "R3");
    check(framingErr == 1'b0, "R7 no error on slot-wide sync", framingErr, 0);
    doReset("R7");

    // R4 R5: 128 frame, 16-bit slots then 32-bit slots
    setCfg(2, 1, 0);
    startStream();
    playFrame(2, 1, 0, 2, 1, 0, 1, "R5");
    playFrame(2, 1, 0, 1, 1, 0, 1, "R4");
    playFrame(1, 1, 0, 1, 1, 0, 1, "R4");
    check(framingErr == 1'b0, "R4 no error on short frame", framingErr, 0);
    doReset("R4");

    // R10: configuration flips in mid-frame
    setCfg(2, 0, 0);
    startStream();
    playFrame(2, 0, 0, 1, 1, 0, 1, "R10");
    playFrame(1, 1, 0, 0, 0, 1, 1, "R10");
    playFrame(0, 0, 127, 0, 0, 1, 1, "R10");
    check(framingErr == 1'b0, "R10 no error across changes", framingErr, 0);
    doReset("R10");

    // R6: pulse-style sync held one clock too long
    setCfg(2, 0, 0);
    startStream();
    @(negedge clk);
    frameSync = 1'b1;
    #1;
    check(framingErr == 1'b0, "R6 error before violation", framingErr, 0);
    expQ.delete();
    doReset("R6");
    setCfg(2, 0, 0);
    startStream();
    playFrame(2, 0, 1, 2, 0, 0, 1, "R6");
    check(framingErr == 1'b1, "R6 long pulse flagged", framingErr, 1);
    doReset("R6");

    // R7: slot-wide sync falling early
    setCfg(1, 0, 1);
    startStream();
    playFrame(1, 0, 60, 1, 0, 1, 1, "R7");
    check(framingErr == 1'b1, "R7 early fall flagged", framingErr, 1);
    doReset("R7");

    // R8 R9: rise in mid-slot, then realigned frames
    setCfg(2, 0, 0);
    startStream();
    playFrame(2, 0, 0, 2, 0, 0, 0, "R8");
    check(framingErr == 1'b0, "R8 error before misplaced rise", framingErr, 0);
    partialFrame(2, 0, 100, "R8");
    playFrame(2, 0, 0, 2, 0, 0, 1, "R8");
    check(framingErr == 1'b1, "R8 misplaced rise flagged", framingErr, 1);
    playFrame(2, 0, 0, 2, 0, 0, 1, "R9");
    check(framingErr == 1'b1, "R9 error stays set", framingErr, 1);
    doReset("R9");
    check(framingErr == 1'b0, "R9 reset clears error", framingErr, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule